// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Unit

This unit sits between the fetch queue and two execution pipes of a dual-issue integer core. Each cycle it looks at the two oldest fetched instructions, the older and the younger. It decides how many of them leave the queue, from zero to two, and which pipe each one enters. The instructions arrive already pre-decoded. One pipe is a function pipe. It takes integer, branch, floating-point and multiply/divide work. The other is a memory pipe. It takes integer and load/store work. Each pipe accepts at most one instruction per cycle.

The decision is purely combinational. The fetch queue pops the entries marked in the consume mask on the same clock edge. Program order is always kept: the younger instruction never leaves ahead of the older one. A plain integer instruction can go to either pipe, so it can fill whichever pipe its partner leaves free. A register dependence inside the pair splits the pair: only the older instruction issues that cycle. The clock and reset feed only the embedded property checks.

Top module: `pipe_steer`

## Requirements
- R1: The class codes are 0 integer, 1 load/store, 2 branch and 3 floating-point. The pipe codes are 0 for the function pipe and 1 for the memory pipe. An issued branch, floating-point, or integer instruction with the multiply/divide/HI-LO-move flag set always gets pipe code 0.
- R2: An issued load/store instruction (class 1) always gets pipe code 1, whatever the value of its multiply/divide flag.
- R3: A plain integer instruction (class 0, flag clear) that issues alone goes to the function pipe. When paired, it takes whichever pipe its partner leaves free.
- R4: Both instructions issue (issue count 2) only when they can be placed in different pipes. Two instructions that both need the function pipe, or both need the memory pipe, issue as one (issue count 1).
- R5: When both instructions are plain integer and they pair, the older one gets pipe code 0 and the younger one gets pipe code 1.
- R6: The pair does not dual-issue when the younger instruction's destination, first source or second source equals a nonzero destination of the older instruction. In that case the issue count is 1.
- R7: A destination number of 0 in the older instruction never blocks pairing.
- R8: If the older slot is invalid, the issue count is 0 and the consume mask is 0, even when the younger slot is valid. If the younger slot is invalid, the issue count is at most 1.
- R9: While the stall input is high, the issue count is 0 and the consume mask is 0.
- R10: Consume bit 0 marks the older entry and bit 1 marks the younger entry. The number of set bits equals the issue count, and bit 1 is set only with bit 0. The pipe output of a slot that does not issue reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset; disables the property checks |
| stall | input | 1 | Downstream stall; blocks all issue |
| old_valid | input | 1 | Older slot holds an instruction |
| old_cls | input | 2 | Older issue class |
| old_md | input | 1 | Older is multiply/divide or HI/LO move |
| old_dst | input | REG_W | Older destination register |
| yng_valid | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 2 | Younger issue class |
| yng_md | input | 1 | Younger is multiply/divide or HI/LO move |
| yng_dst | input | REG_W | Younger destination register |
| yng_srca | input | REG_W | Younger first source register |
| yng_srcb | input | REG_W | Younger second source register |
| old_pipe | output | 1 | Pipe given to the older slot |
| yng_pipe | output | 1 | Pipe given to the younger slot |
| issue_cnt | output | 2 | Number of instructions issued |
| consume | output | 2 | Pop mask sent to the fetch queue |

## Verification
Some rules hold on every cycle, and the embedded properties check them each cycle. A stall blocks all issue. A dual issue never puts both instructions in one pipe. Load/store instructions only enter the memory pipe, and function-only work only enters the function pipe. The consume mask agrees with the issue count and keeps program order. Other behaviour only the bench scenarios can show. These are the choice of pairing against a dependence, the exemption of register 0, the older-function/younger-memory placement of two plain integer instructions, and a single plain integer instruction landing in the function pipe. The bench compares these with a model built from the requirements, over directed corners and a seeded random mix with a narrow register range.

// File: rtl/steer_pkg.sv
package steer_pkg;

   typedef enum logic [1:0] {
      CLS_INT  = 2'd0,
      CLS_LDST = 2'd1,
      CLS_BR   = 2'd2,
      CLS_FP   = 2'd3
   } issue_cls_e;

   localparam logic PIPE_FN  = 1'b0;
   localparam logic PIPE_MEM = 1'b1;

   typedef struct packed {
      logic fn_ok;
      logic mem_ok;
   } pipe_fit_t;

endpackage

// File: rtl/steer_fit.sv
module steer_fit
   import steer_pkg::*;
(
   input  logic [1:0] cls,
   input  logic       md,
   output pipe_fit_t  fit
);
   issue_cls_e c;
   always_comb begin
      c          = issue_cls_e'(cls);
      fit.fn_ok  = (c != CLS_LDST);
      fit.mem_ok = (c == CLS_LDST) || ((c == CLS_INT) && !md);
   end
endmodule

// File: rtl/steer_dep.sv
module steer_dep #(
   parameter int REG_W     = 5,
   parameter bit EXEMPT_R0 = 1'b1
) (
   input  logic [REG_W-1:0] old_dst,
   input  logic [REG_W-1:0] yng_dst,
   input  logic [REG_W-1:0] yng_srca,
   input  logic [REG_W-1:0] yng_srcb,
   output logic             conflict
);
   logic live;
   logic hit;

   generate
      if (EXEMPT_R0) begin : g_r0_free
         assign live = |old_dst;
      end else begin : g_r0_real
         assign live = 1'b1;
      end
   endgenerate

   assign hit      = (yng_dst == old_dst) || (yng_srca == old_dst) || (yng_srcb == old_dst);
   assign conflict = live && hit;
endmodule

// File: rtl/steer_pick.sv
module steer_pick
   import steer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       yng_valid,
   input  logic       conflict,
   input  pipe_fit_t  fit_o,
   input  pipe_fit_t  fit_y,
   output logic       old_pipe,
   output logic       yng_pipe,
   output logic [1:0] take
);
   logic fm_ok, mf_ok, pair;

   always_comb begin
      fm_ok    = fit_o.fn_ok && fit_y.mem_ok;
      mf_ok    = fit_o.mem_ok && fit_y.fn_ok;
      pair     = go && yng_valid && !conflict && (fm_ok || mf_ok);
      take     = {pair, go};
      old_pipe = PIPE_FN;
      yng_pipe = PIPE_FN;
      if (pair) begin
         old_pipe = fm_ok ? PIPE_FN  : PIPE_MEM;
         yng_pipe = fm_ok ? PIPE_MEM : PIPE_FN;
      end else if (go) begin
         old_pipe = fit_o.fn_ok ? PIPE_FN : PIPE_MEM;
      end
   end

   // R4: a dual issue splits the pair across both pipes
   p_split_pipes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take[1] |-> (old_pipe != yng_pipe));
   // R10: younger never leaves without the older
   p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take[1] |-> take[0]);
endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
   import steer_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit EXEMPT_R0 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall,
   input  logic             old_valid,
   input  logic [1:0]       old_cls,
   input  logic             old_md,
   input  logic [REG_W-1:0] old_dst,
   input  logic             yng_valid,
   input  logic [1:0]       yng_cls,
   input  logic             yng_md,
   input  logic [REG_W-1:0] yng_dst,
   input  logic [REG_W-1:0] yng_srca,
   input  logic [REG_W-1:0] yng_srcb,
   output logic             old_pipe,
   output logic             yng_pipe,
   output logic [1:0]       issue_cnt,
   output logic [1:0]       consume
);
   localparam int NUM_SLOTS = 2;

   initial begin
      if (REG_W < 1 || REG_W > 8) $error("pipe_steer: REG_W out of range");
   end

   logic [1:0] cls_v [NUM_SLOTS];
   logic       md_v  [NUM_SLOTS];
   pipe_fit_t  fit_v [NUM_SLOTS];

   assign cls_v[0] = old_cls;
   assign cls_v[1] = yng_cls;
   assign md_v[0]  = old_md;
   assign md_v[1]  = yng_md;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_fit
         steer_fit u_fit (.cls(cls_v[s]), .md(md_v[s]), .fit(fit_v[s]));
      end
   endgenerate

   logic conflict;
   steer_dep #(.REG_W(REG_W), .EXEMPT_R0(EXEMPT_R0)) u_dep (
      .old_dst(old_dst), .yng_dst(yng_dst), .yng_srca(yng_srca),
      .yng_srcb(yng_srcb), .conflict(conflict));

   logic go;
   logic [1:0] take;
   assign go = old_valid && !stall;

   steer_pick u_pick (
      .clk(clk), .rst_n(rst_n), .go(go), .yng_valid(yng_valid),
      .conflict(conflict), .fit_o(fit_v[0]), .fit_y(fit_v[1]),
      .old_pipe(old_pipe), .yng_pipe(yng_pipe), .take(take));

   assign consume = take;
   always_comb begin
      unique case (take)
         2'b11:   issue_cnt = 2'd2;
         2'b01:   issue_cnt = 2'd1;
         default: issue_cnt = 2'd0;
      endcase
   end

   // R9: stall blocks everything
   p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (issue_cnt == 2'd0 && consume == 2'b00));
   // R2: load/store only into the memory pipe
   p_ldst_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (consume[0] && old_cls == 2'd1) |-> old_pipe == PIPE_MEM);
   // R1: function-only work only into the function pipe
   p_fn_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (consume[1] && (yng_cls[1] || (yng_cls == 2'd0 && yng_md))) |-> yng_pipe == PIPE_FN);
   // R10: pop mask size matches issue count
   p_consume_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(consume) == int'(issue_cnt));
   // R8: no issue without an older instruction
   p_old_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !old_valid |-> issue_cnt == 2'd0);
endmodule

// File: tb/pipe_steer_test.sv
module pipe_steer_test;
   localparam int REG_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stall = 1'b0;
   logic old_valid = 1'b0, yng_valid = 1'b0;
   logic [1:0] old_cls = '0, yng_cls = '0;
   logic old_md = 1'b0, yng_md = 1'b0;
   logic [REG_W-1:0] old_dst = '0, yng_dst = '0, yng_srca = '0, yng_srcb = '0;
   logic old_pipe, yng_pipe;
   logic [1:0] issue_cnt, consume;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pipe_steer #(.REG_W(REG_W)) uut (
      .clk(clk), .rst_n(rst_n), .stall(stall),
      .old_valid(old_valid), .old_cls(old_cls), .old_md(old_md), .old_dst(old_dst),
      .yng_valid(yng_valid), .yng_cls(yng_cls), .yng_md(yng_md), .yng_dst(yng_dst),
      .yng_srca(yng_srca), .yng_srcb(yng_srcb),
      .old_pipe(old_pipe), .yng_pipe(yng_pipe), .issue_cnt(issue_cnt), .consume(consume));

   // expected {issue_cnt, old_pipe, yng_pipe, consume}
   function automatic logic [5:0] model();
      logic fo, mo, fy, my, dep;
      fo  = old_cls != 2'd1;
      mo  = old_cls == 2'd1 || (old_cls == 2'd0 && !old_md);
      fy  = yng_cls != 2'd1;
      my  = yng_cls == 2'd1 || (yng_cls == 2'd0 && !yng_md);
      dep = old_dst != 0 && (yng_dst == old_dst || yng_srca == old_dst || yng_srcb == old_dst);
      if (stall || !old_valid) return 6'b00_0_0_00;
      if (yng_valid && !dep && fo && my) return 6'b10_0_1_11;
      if (yng_valid && !dep && mo && fy) return 6'b10_1_0_11;
      return {2'd1, !fo, 1'b0, 2'b01};
   endfunction

   task automatic compare(string req);
      logic [5:0] exp, got;
      exp = model();
      got = {issue_cnt, old_pipe, yng_pipe, consume};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got cnt=%0d op=%0b yp=%0b cons=%b expected cnt=%0d op=%0b yp=%0b cons=%b",
                  req, got[5:4], got[3], got[2], got[1:0], exp[5:4], exp[3], exp[2], exp[1:0]);
      end
   endtask

   task automatic apply(input logic st, input logic v0, input logic [1:0] c0, input logic m0,
                        input int d0, input logic v1, input logic [1:0] c1, input logic m1,
                        input int d1, input int a1, input int b1, input string req);
      @(negedge clk);
      stall = st; old_valid = v0; old_cls = c0; old_md = m0; old_dst = REG_W'(d0);
      yng_valid = v1; yng_cls = c1; yng_md = m1; yng_dst = REG_W'(d1);
      yng_srca = REG_W'(a1); yng_srcb = REG_W'(b1);
      #2 compare(req);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      repeat (2) @(negedge clk);
      #2 compare("R8 reset state");
      @(negedge clk) rst_n = 1'b1;
      // R1 branch + load/store pair
      apply(0,1,2'd2,0,3, 1,2'd1,0,4,5,6, "R1 branch with ldst");
      apply(0,1,2'd3,0,3, 1,2'd3,0,4,5,6, "R4 fp fp single");
      apply(0,1,2'd0,1,3, 1,2'd0,0,4,5,6, "R1 muldiv with int");
      apply(0,1,2'd0,0,3, 1,2'd0,1,4,5,6, "R1 int with muldiv");
      apply(0,1,2'd1,0,3, 1,2'd1,0,4,5,6, "R2 ldst ldst single");
      apply(0,1,2'd1,1,3, 1,2'd2,0,4,5,6, "R2 ldst md flag ignored");
      apply(0,1,2'd0,0,3, 0,2'd0,0,4,5,6, "R3 int alone");
      apply(0,1,2'd1,0,3, 1,2'd0,0,4,5,6, "R3 ldst then int");
      apply(0,1,2'd0,0,3, 1,2'd0,0,4,5,6, "R5 int int");
      apply(0,1,2'd0,0,3, 1,2'd1,0,4,3,6, "R6 read after write");
      apply(0,1,2'd0,0,3, 1,2'd1,0,4,6,3, "R6 second source");
      apply(0,1,2'd0,0,3, 1,2'd1,0,3,5,6, "R6 same destination");
      apply(0,1,2'd0,0,0, 1,2'd1,0,0,0,0, "R7 register zero");
      apply(0,0,2'd0,0,3, 1,2'd1,0,4,5,6, "R8 older invalid");
      apply(0,1,2'd2,0,3, 0,2'd1,0,4,5,6, "R8 younger invalid");
      apply(1,1,2'd0,0,3, 1,2'd1,0,4,5,6, "R9 stall");
      apply(0,1,2'd3,0,3, 1,2'd2,0,4,5,6, "R10 pipe zero when held");
      for (int i = 0; i < 3000; i++) begin
         apply(($urandom % 8) == 0, ($urandom % 8) != 0, 2'($urandom), ($urandom % 4) == 0,
               int'($urandom % 4), ($urandom % 6) != 0, 2'($urandom), ($urandom % 4) == 0,
               int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
               "random R1 R2 R3 R4 R5 R6 R7 R9 R10");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule